// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block recovers characters from a single serial data line. The frame format is chosen at run time: 5 to 9 data bits, parity that is off, even or odd, and one or two stop bits. A frame opens with a low start bit. The data bits follow, least significant first. The parity bit comes next when it is enabled, and then the stop bits. The line rests high between frames. A new start bit may follow the last stop bit with no gap.

Two sampling modes are available. In asynchronous mode the receiver runs from an external oversampling tick, at 16 ticks per bit by default. It arms on a falling edge of the idle line and checks the start bit again at its centre. A line that has already returned high there is treated as a glitch. Each later bit is sampled at the centre of its period. In synchronous mode a serial clock comes in alongside the data. Bits are taken on the clock edge that the sender does not use for changing data, and a polarity input selects that edge. For each frame the receiver gives the assembled word with a one-cycle strobe, a parity-error flag and a framing-error flag.

Top module: `usart_frame_rx`

## Requirements
- R1: After reset, rx_valid, rx_par_err, rx_frm_err and every bit of rx_word are 0, and an idle line held high produces no strobe.
- R2: In asynchronous mode a falling edge on the line arms the receiver, and the start bit is checked again half a bit period later. If the line is high at that point, the event is dropped and no word is produced.
- R3: Data bits are placed least significant bit first into rx_word[n-1:0], where n is the number of data bits. Bits of rx_word at and above n read 0.
- R4: In asynchronous mode every bit after the start bit is sampled once, OS_RATE ticks (16 by default) after the previous sample, which keeps each sample at the centre of its bit.
- R5: With cfg_par_en = 1, one parity bit is expected directly after the last data bit. rx_par_err is 1 when that bit differs from the XOR of the data bits (cfg_par_odd = 0) or from its inverse (cfg_par_odd = 1). With cfg_par_en = 0 no parity bit is expected and rx_par_err stays 0.
- R6: rx_frm_err is 1 exactly when the first stop bit is sampled low. A second stop bit is never examined.
- R7: After the first stop bit has been sampled, rx_valid is high for exactly one clock cycle. rx_word, rx_par_err and rx_frm_err are valid in that same cycle.
- R8: In synchronous mode the line is sampled on the falling edge of ser_clk when cfg_clk_pol = 0 and on the rising edge when cfg_clk_pol = 1. A start bit is a 0 sampled while the receiver is idle.
- R9: A frame whose start bit follows the previous stop bit with no idle time is received correctly.
- R10: A cfg_data_bits value below 5 is treated as 5, and a value above 9 is treated as 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync | input | 1 | 1 selects synchronous mode, 0 selects asynchronous mode |
| cfg_clk_pol | input | 1 | Sampling edge in synchronous mode: 0 falling, 1 rising |
| cfg_data_bits | input | 4 | Number of data bits (clamped to 5..9) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| os_tick | input | 1 | Oversampling tick, one clk cycle wide |
| ser_clk | input | 1 | Serial clock used in synchronous mode |
| rx_in | input | 1 | Serial data line |
| rx_word | output | 9 | Received word, right aligned |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_par_err | output | 1 | Parity mismatch for the word being strobed |
| rx_frm_err | output | 1 | First stop bit was low for the word being strobed |

## Verification
The asynchronous sweep covers every data length with each parity mode and each stop count. For each format it sends three kinds of word. An all-ones word and an all-zeros word show whether the word boundary is placed correctly and whether the upper bits are cleared. A mixed word shows whether the bits land in LSB-first order. Some frames carry a flipped parity bit, and these separate the even and odd mismatch rules from correct frames. The stop-bit cases show that only the first stop bit is judged. Synchronous frames drive new data a few cycles after the non-sampling edge and put garbage on the line after the sampling edge, so a receiver that used the wrong edge would return a shifted word. A start pulse that is too short, clamped lengths and frames sent back to back complete the cases.

// File: rtl/usart_rx_pkg.sv
package usart_rx_pkg;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_t;

  typedef enum logic [1:0] {
    SM_HUNT,
    SM_CHECK,
    SM_RUN
  } sm_state_t;

  // Limit a requested data length to the supported range.
  function automatic int clamp_len(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/usart_rx_front.sv
module usart_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic sclk_in,
  input  logic cfg_pol,
  output logic rx_s,
  output logic rx_fall,
  output logic sclk_edge
);

  logic [SYNC_STAGES-1:0] rx_q;
  logic [SYNC_STAGES-1:0] ck_q;
  logic [SYNC_STAGES-1:0] rx_q_n;
  logic [SYNC_STAGES-1:0] ck_q_n;
  logic                   rx_prev;
  logic                   ck_prev;
  logic                   ck_s;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb begin
        rx_q_n = {rx_q[SYNC_STAGES-2:0], rx_in};
        ck_q_n = {ck_q[SYNC_STAGES-2:0], sclk_in};
      end
    end else begin : g_single
      always_comb begin
        rx_q_n = rx_in;
        ck_q_n = sclk_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '1;
      ck_q    <= '0;
      rx_prev <= 1'b1;
      ck_prev <= 1'b0;
    end else begin
      rx_q    <= rx_q_n;
      ck_q    <= ck_q_n;
      rx_prev <= rx_s;
      ck_prev <= ck_s;
    end
  end

  assign rx_s      = rx_q[SYNC_STAGES-1];
  assign ck_s      = ck_q[SYNC_STAGES-1];
  assign rx_fall   = rx_prev & ~rx_s;
  assign sclk_edge = cfg_pol ? (ck_s & ~ck_prev) : (~ck_s & ck_prev);

  AST_SCLK_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_edge |=> !sclk_edge); // R8

endmodule

// File: rtl/usart_rx_sampler.sv
module usart_rx_sampler
  import usart_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sync,
  input  logic os_tick,
  input  logic rx_s,
  input  logic rx_fall,
  input  logic sclk_edge,
  input  logic frame_done,
  input  logic frame_idle,
  output logic smp_stb,
  output logic smp_start,
  output logic smp_bit
);

  localparam int CW   = (OS_RATE > 2) ? $clog2(OS_RATE) : 1;
  localparam int HALF = OS_RATE / 2;

  sm_state_t       state, state_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic            a_start, a_stb;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    a_start = 1'b0;
    a_stb   = 1'b0;
    if (mode_sync) begin
      state_n = SM_HUNT;
      cnt_n   = '0;
    end else begin
      unique case (state)
        SM_HUNT: begin
          if (rx_fall) begin
            state_n = SM_CHECK;
            cnt_n   = '0;
          end
        end
        SM_CHECK: begin
          if (os_tick) begin
            if (cnt == CW'(HALF - 1)) begin
              cnt_n = '0;
              if (!rx_s) begin
                state_n = SM_RUN;
                a_start = 1'b1;
              end else begin
                state_n = SM_HUNT;
              end
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end
        end
        SM_RUN: begin
          if (frame_done) begin
            state_n = SM_HUNT;
            cnt_n   = '0;
          end else if (os_tick) begin
            if (cnt == CW'(OS_RATE - 1)) begin
              cnt_n = '0;
              a_stb = 1'b1;
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end
        end
        default: state_n = SM_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SM_HUNT;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  assign smp_bit   = rx_s;
  assign smp_stb   = mode_sync ? sclk_edge : a_stb;
  assign smp_start = mode_sync ? (sclk_edge & ~rx_s & frame_idle) : a_start;

  AST_ASYNC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && (smp_stb || smp_start)) |-> os_tick); // R4

  AST_CHECK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SM_CHECK && $past(state) == SM_HUNT) |-> $past(rx_fall)); // R2

endmodule

// File: rtl/usart_rx_framer.sv
module usart_rx_framer
  import usart_rx_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LEN_W-1:0]    cfg_bits,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                smp_stb,
  input  logic                smp_start,
  input  logic                smp_bit,
  output logic [MAX_BITS-1:0] word_o,
  output logic                vld_o,
  output logic                perr_o,
  output logic                ferr_o,
  output logic                idle_o
);

  fr_state_t             state, state_n;
  logic [LEN_W-1:0]      idx, idx_n;
  logic [MAX_BITS-1:0]   data, data_n;
  logic                  acc, acc_n;
  logic                  perr, perr_n;
  logic [MAX_BITS-1:0]   word_n;
  logic                  vld_n, perr_o_n, ferr_o_n;
  logic [LEN_W-1:0]      nb;

  assign nb = LEN_W'(clamp_len(int'(cfg_bits), MIN_BITS, MAX_BITS));

  always_comb begin
    state_n  = state;
    idx_n    = idx;
    data_n   = data;
    acc_n    = acc;
    perr_n   = perr;
    word_n   = word_o;
    vld_n    = 1'b0;
    perr_o_n = perr_o;
    ferr_o_n = ferr_o;
    unique case (state)
      FR_IDLE: begin
        if (smp_start) begin
          state_n = FR_DATA;
          idx_n   = '0;
          data_n  = '0;
          acc_n   = 1'b0;
          perr_n  = 1'b0;
        end
      end
      FR_DATA: begin
        if (smp_stb) begin
          data_n[idx] = smp_bit;
          acc_n       = acc ^ smp_bit;
          idx_n       = idx + 1'b1;
          if (idx == nb - 1'b1) begin
            state_n = cfg_par_en ? FR_PAR : FR_STOP;
          end
        end
      end
      FR_PAR: begin
        if (smp_stb) begin
          perr_n  = smp_bit ^ acc ^ cfg_par_odd;
          state_n = FR_STOP;
        end
      end
      FR_STOP: begin
        if (smp_stb) begin
          word_n   = data;
          vld_n    = 1'b1;
          perr_o_n = perr & cfg_par_en;
          ferr_o_n = ~smp_bit;
          state_n  = FR_IDLE;
        end
      end
      default: state_n = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FR_IDLE;
      idx    <= '0;
      data   <= '0;
      acc    <= 1'b0;
      perr   <= 1'b0;
      word_o <= '0;
      vld_o  <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      state  <= state_n;
      idx    <= idx_n;
      data   <= data_n;
      acc    <= acc_n;
      perr   <= perr_n;
      word_o <= word_n;
      vld_o  <= vld_n;
      perr_o <= perr_o_n;
      ferr_o <= ferr_o_n;
    end
  end

  assign idle_o = (state == FR_IDLE);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o); // R7

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ((word_o >> nb) == '0)); // R3

  AST_NO_PAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !cfg_par_en) |-> !perr_o); // R5

  AST_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ($past(state) == FR_STOP)); // R6

endmodule

// File: rtl/usart_frame_rx.sv
module usart_frame_rx #(
  parameter int MIN_BITS    = 5,
  parameter int MAX_BITS    = 9,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sync,
  input  logic                cfg_clk_pol,
  input  logic [LEN_W-1:0]    cfg_data_bits,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                os_tick,
  input  logic                ser_clk,
  input  logic                rx_in,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                rx_valid,
  output logic                rx_par_err,
  output logic                rx_frm_err
);

  logic rx_s, rx_fall, sclk_edge;
  logic smp_stb, smp_start, smp_bit;
  logic frame_idle;

  usart_rx_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_in     (rx_in),
    .sclk_in   (ser_clk),
    .cfg_pol   (cfg_clk_pol),
    .rx_s      (rx_s),
    .rx_fall   (rx_fall),
    .sclk_edge (sclk_edge)
  );

  usart_rx_sampler #(
    .OS_RATE(OS_RATE)
  ) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sync  (cfg_sync),
    .os_tick    (os_tick),
    .rx_s       (rx_s),
    .rx_fall    (rx_fall),
    .sclk_edge  (sclk_edge),
    .frame_done (rx_valid),
    .frame_idle (frame_idle),
    .smp_stb    (smp_stb),
    .smp_start  (smp_start),
    .smp_bit    (smp_bit)
  );

  usart_rx_framer #(
    .MIN_BITS (MIN_BITS),
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W)
  ) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_bits    (cfg_data_bits),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .smp_stb     (smp_stb),
    .smp_start   (smp_start),
    .smp_bit     (smp_bit),
    .word_o      (rx_word),
    .vld_o       (rx_valid),
    .perr_o      (rx_par_err),
    .ferr_o      (rx_frm_err),
    .idle_o      (frame_idle)
  );

endmodule

// File: tb/sim_usart_frame_rx.sv
module sim_usart_frame_rx;

  logic       clk;
  logic       rst_n;
  logic       cfg_sync;
  logic       cfg_clk_pol;
  logic [3:0] cfg_data_bits;
  logic       cfg_par_en;
  logic       cfg_par_odd;
  logic       os_tick;
  logic       ser_clk;
  logic       rx_in;
  logic [8:0] rx_word;
  logic       rx_valid;
  logic       rx_par_err;
  logic       rx_frm_err;

  int checks   = 0;
  int failures = 0;
  int ncap     = 0;
  int seen     = 0;
  logic [8:0] cap_word;
  logic       cap_perr;
  logic       cap_ferr;
  bit         done = 0;

  localparam int BIT_CLKS = 32; // 16 ticks, one tick every 2 clocks

  usart_frame_rx u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_sync      (cfg_sync),
    .cfg_clk_pol   (cfg_clk_pol),
    .cfg_data_bits (cfg_data_bits),
    .cfg_par_en    (cfg_par_en),
    .cfg_par_odd   (cfg_par_odd),
    .os_tick       (os_tick),
    .ser_clk       (ser_clk),
    .rx_in         (rx_in),
    .rx_word       (rx_word),
    .rx_valid      (rx_valid),
    .rx_par_err    (rx_par_err),
    .rx_frm_err    (rx_frm_err)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    os_tick = 1'b0;
    forever begin
      @(negedge clk);
      os_tick = ~os_tick;
    end
  end

  initial begin
    cap_word = '0;
    cap_perr = 1'b0;
    cap_ferr = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        ncap++;
        cap_word = rx_word;
        cap_perr = rx_par_err;
        cap_ferr = rx_frm_err;
      end
    end
  end

  function automatic logic xor_bits(input logic [8:0] w, input int nb);
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= w[i];
    return p;
  endfunction

  task automatic put_bit(input logic b);
    rx_in = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic send_async(input logic [8:0] w, input int nb, input int pm,
                            input logic flip, input logic stop1,
                            input int nstop, input logic stop2);
    put_bit(1'b0);
    for (int i = 0; i < nb; i++) put_bit(w[i]);
    if (pm != 0) put_bit(xor_bits(w, nb) ^ (pm == 2) ^ flip);
    put_bit(stop1);
    if (nstop == 2) put_bit(stop2);
  endtask

  task automatic sync_bit(input logic b);
    ser_clk = ~ser_clk;               // change edge
    repeat (3) @(negedge clk);
    rx_in = b;
    repeat (5) @(negedge clk);
    ser_clk = ~ser_clk;               // sampling edge
    repeat (4) @(negedge clk);
    rx_in = ~b;                       // garbage between samples
    repeat (4) @(negedge clk);
  endtask

  task automatic send_sync(input logic [8:0] w, input int nb, input int pm);
    sync_bit(1'b0);
    for (int i = 0; i < nb; i++) sync_bit(w[i]);
    if (pm != 0) sync_bit(xor_bits(w, nb) ^ (pm == 2));
    sync_bit(1'b1);
    sync_bit(1'b1);
    rx_in = 1'b1;
  endtask

  task automatic check_frame(input string tag, input logic [8:0] ew,
                             input logic ep, input logic ef);
    checks++;
    if (ncap != seen + 1 || cap_word !== ew || cap_perr !== ep || cap_ferr !== ef) begin
      failures++;
      $display("FAIL %s: frames=%0d word=%h perr=%b ferr=%b expected frames=%0d word=%h perr=%b ferr=%b",
               tag, ncap - seen, cap_word, cap_perr, cap_ferr, 1, ew, ep, ef);
    end
    seen = ncap;
  endtask

  task automatic check_none(input string tag);
    checks++;
    if (ncap != seen) begin
      failures++;
      $display("FAIL %s: frames=%0d expected frames=0", tag, ncap - seen);
    end
    seen = ncap;
  endtask

  initial begin
    rst_n         = 1'b0;
    cfg_sync      = 1'b0;
    cfg_clk_pol   = 1'b0;
    cfg_data_bits = 4'd8;
    cfg_par_en    = 1'b0;
    cfg_par_odd   = 1'b0;
    ser_clk       = 1'b0;
    rx_in         = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    checks++;
    if (rx_valid !== 1'b0 || rx_word !== 9'd0 || rx_par_err !== 1'b0 || rx_frm_err !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: valid=%b word=%h perr=%b ferr=%b expected 0 0 0 0",
               rx_valid, rx_word, rx_par_err, rx_frm_err);
    end
    rst_n = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check_none("R1 idle line");

    // R3 R4 R5 R7 R9: asynchronous sweep, frames back to back
    for (int nb = 5; nb <= 9; nb++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int ns = 1; ns <= 2; ns++) begin
          for (int k = 0; k < 3; k++) begin
            logic [8:0] w, mask;
            logic flip;
            mask = 9'((1 << nb) - 1);
            w = (k == 0) ? 9'h1FF : (k == 1) ? 9'h000 : 9'(9'h0A5 ^ 9'(nb * 29 + pm * 7));
            flip = (pm != 0) && (k == 2) && (ns == 2);
            cfg_data_bits = 4'(nb);
            cfg_par_en    = (pm != 0);
            cfg_par_odd   = (pm == 2);
            send_async(w, nb, pm, flip, 1'b1, ns, 1'b1);
            check_frame("R3/R4/R5/R7/R9 async sweep", w & mask, flip, 1'b0);
          end
        end
      end
    end
    rx_in = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);

    // R2: short start pulse is a glitch
    cfg_data_bits = 4'd8;
    cfg_par_en    = 1'b0;
    rx_in = 1'b0;
    repeat (6) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    check_none("R2 glitch dropped");
    send_async(9'h0C3, 8, 0, 1'b0, 1'b1, 1, 1'b1);
    check_frame("R2 frame after glitch", 9'h0C3, 1'b0, 1'b0);

    // R10: length clamp
    cfg_data_bits = 4'd3;
    send_async(9'h1F6, 5, 0, 1'b0, 1'b1, 1, 1'b1);
    check_frame("R10 clamp low", 9'h016, 1'b0, 1'b0);
    cfg_data_bits = 4'd12;
    send_async(9'h15A, 9, 0, 1'b0, 1'b1, 1, 1'b1);
    check_frame("R10 clamp high", 9'h15A, 1'b0, 1'b0);

    // R6: first stop low flags, second stop low does not
    cfg_data_bits = 4'd7;
    send_async(9'h055, 7, 0, 1'b0, 1'b0, 1, 1'b1);
    check_frame("R6 first stop low", 9'h055, 1'b0, 1'b1);
    rx_in = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    seen = ncap;
    send_async(9'h02A, 7, 0, 1'b0, 1'b1, 2, 1'b0);
    check_frame("R6 second stop ignored", 9'h02A, 1'b0, 1'b0);
    rx_in = 1'b1;
    repeat (16 * BIT_CLKS) @(negedge clk); // absorb frame started by low line
    seen = ncap;

    // R8: synchronous mode, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      cfg_clk_pol = pol[0];
      ser_clk     = pol[0];
      repeat (8) @(negedge clk);
      cfg_sync = 1'b1;
      repeat (8) @(negedge clk);
      seen = ncap;
      for (int nb = 5; nb <= 9; nb++) begin
        for (int pm = 0; pm < 3; pm++) begin
          for (int k = 0; k < 2; k++) begin
            logic [8:0] w, mask;
            mask = 9'((1 << nb) - 1);
            w = (k == 0) ? 9'(9'h139 ^ 9'(nb * 13 + pol * 71)) : 9'(9'h0CE + 9'(pm * 37));
            cfg_data_bits = 4'(nb);
            cfg_par_en    = (pm != 0);
            cfg_par_odd   = (pm == 2);
            send_sync(w, nb, pm);
            check_frame(pol == 0 ? "R8 sync falling edge" : "R8 sync rising edge",
                        w & mask, 1'b0, 1'b0);
          end
        end
      end
      cfg_sync = 1'b0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule